// File: doc/BRIEF.md
# Register History Buffer with Rollback

This block lets instructions write the register file the moment they complete, and keeps enough history to undo those writes. Each instruction claims an entry at decode, in program order, and receives that entry's index as its tag. When the instruction completes, its result goes straight into the register file. In the same cycle, the value the destination held just before is copied into the instruction's entry. Operand reads go to the register file alone.

The oldest entry leaves the buffer once it has completed. If it completed cleanly, it is dropped. If it raised an exception, a rollback begins. The rollback walks from the youngest entry back to the oldest, one entry per cycle, and writes each saved value back to its register. Entries that never completed are passed over. When the walk ends, the buffer is emptied and a one-cycle done pulse is given. The register file is then in the state it had before the excepting instruction. Execution units lie outside the block and drive the completion port.

Top module: `history_buffer`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready_o` is 1, `alloc_tag_o` is 0, `retire_o`, `rollback_busy_o` and `rollback_done_o` are 0, and every register reads 0.
- R2: Each accepted allocation returns the tag shown on `alloc_tag_o`. Tags count up by one per allocation, in program order, and wrap after DEPTH-1. Once DEPTH entries are held, `alloc_ready_o` is 0.
- R3: An accepted completion writes `cmpl_data_i` to the entry's destination. The new value reads back on `rd_data_o` in the cycle after the completion edge.
- R4: A completion has no effect if its tag names an entry that is not allocated, or one that has already completed.
- R5: `retire_o` pulses once for each oldest entry that has completed without an exception. An uncompleted oldest entry holds back every younger entry, even younger entries that have completed.
- R6: When the oldest entry has completed with `cmpl_exc_i` set, a rollback starts at the next edge. While it runs, `rollback_busy_o` is 1 and `alloc_ready_o` is 0.
- R7: Rollback restores saved values from the youngest entry to the oldest. `rollback_busy_o` stays high for exactly one cycle per held entry. A register written by several entries, completed in program order, returns to the value it held before the oldest of those entries.
- R8: During rollback, entries that never completed leave the register file untouched.
- R9: `rollback_done_o` is high for exactly one cycle, directly after `rollback_busy_o` falls. In the next cycle the buffer is empty, `alloc_ready_o` is 1 and `alloc_tag_o` is 0.
- R10: Completions presented while the rollback runs or during the done cycle are ignored.
- R11: A completion accepted in the cycle in which the excepting oldest entry is first seen is recorded like any other completion, and its write is undone by the rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request at decode |
| alloc_dest_i | input | REG_W | Destination register of the allocating instruction |
| alloc_ready_o | output | 1 | Allocation can be accepted this cycle |
| alloc_tag_o | output | PTR_W | Tag given to the allocating instruction |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_tag_i | input | PTR_W | Tag of the completing instruction |
| cmpl_data_i | input | DATA_W | Result value |
| cmpl_exc_i | input | 1 | Completing instruction raised an exception |
| rd_addr_i | input | REG_W | Operand read address |
| rd_data_o | output | DATA_W | Operand read data (combinational) |
| retire_o | output | 1 | Oldest entry discarded this cycle |
| rollback_busy_o | output | 1 | Rollback walk in progress |
| rollback_done_o | output | 1 | One-cycle pulse when rollback has finished |

## Verification
Two events are made to coincide. The first is the cycle in which the excepting oldest entry is first seen and the rollback decision is taken. The second is the completion of a younger, still-pending instruction. The bench completes the excepting entry and drives that younger completion at the very next edge. It then checks that the younger write was accepted and was still undone. This is judged from the final register contents, read against a bench model that holds only the writes of entries older than the exception. The same sweep also retires older entries in the cycle in which the excepting entry completes, and presents completions throughout the walk, which must leave no trace.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    HB_IDLE = 2'd0,
    HB_ROLL = 2'd1,
    HB_DONE = 2'd2
  } hb_state_e;
endpackage

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [REG_W-1:0]  old_addr_i,
  output logic [DATA_W-1:0] old_data_o,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (wr_en_i && (wr_addr_i == REG_W'(r))) begin
        regs_q[r] <= wr_data_i;
      end
    end
  end

  assign rd_data_o  = regs_q[rd_addr_i];
  assign old_data_o = regs_q[old_addr_i];
endmodule

// File: rtl/hb_entries.sv
module hb_entries #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_en_i,
  input  logic [PTR_W-1:0]               alloc_idx_i,
  input  logic [REG_W-1:0]               alloc_dest_i,
  input  logic                           cmpl_en_i,
  input  logic [PTR_W-1:0]               cmpl_idx_i,
  input  logic                           cmpl_exc_i,
  input  logic [DATA_W-1:0]              cmpl_old_i,
  input  logic                           retire_en_i,
  input  logic [PTR_W-1:0]               retire_idx_i,
  input  logic                           clear_i,
  output logic [DEPTH-1:0]               valid_o,
  output logic [DEPTH-1:0]               done_o,
  output logic [DEPTH-1:0]               exc_o,
  output logic [DEPTH-1:0][REG_W-1:0]    dest_o,
  output logic [DEPTH-1:0][DATA_W-1:0]   old_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_alloc, hit_cmpl, hit_retire;
    assign hit_alloc  = alloc_en_i  && (alloc_idx_i  == PTR_W'(e));
    assign hit_cmpl   = cmpl_en_i   && (cmpl_idx_i   == PTR_W'(e));
    assign hit_retire = retire_en_i && (retire_idx_i == PTR_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[e] <= 1'b0;
        done_o[e]  <= 1'b0;
        exc_o[e]   <= 1'b0;
        dest_o[e]  <= '0;
        old_o[e]   <= '0;
      end else if (clear_i) begin
        valid_o[e] <= 1'b0;
        done_o[e]  <= 1'b0;
      end else begin
        if (hit_alloc) begin
          valid_o[e] <= 1'b1;
          done_o[e]  <= 1'b0;
          exc_o[e]   <= 1'b0;
          dest_o[e]  <= alloc_dest_i;
        end
        if (hit_cmpl) begin
          done_o[e] <= 1'b1;
          exc_o[e]  <= cmpl_exc_i;
          old_o[e]  <= cmpl_old_i;
        end
        if (hit_retire) begin
          valid_o[e] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic             head_valid_i,
  input  logic             head_done_i,
  input  logic             head_exc_i,
  output logic             alloc_en_o,
  output logic             alloc_ready_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] walk_o,
  output logic             retire_o,
  output logic             idle_o,
  output logic             rolling_o,
  output logic             clear_o
);
  hb_state_e        state_q;
  logic [PTR_W-1:0] head_q, tail_q, walk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, head_ready, start_rb;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign idle_o     = (state_q == HB_IDLE);
  assign rolling_o  = (state_q == HB_ROLL);
  assign clear_o    = (state_q == HB_DONE);
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign head_ready = idle_o && head_valid_i && head_done_i;
  assign retire_o   = head_ready && !head_exc_i;
  assign start_rb   = head_ready && head_exc_i;
  // younger allocations are refused once the rollback is decided
  assign alloc_ready_o = idle_o && !full && !start_rb;
  assign alloc_en_o    = alloc_valid_i && alloc_ready_o;
  assign tail_o = tail_q;
  assign head_o = head_q;
  assign walk_o = walk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HB_IDLE;
      head_q  <= '0;
      tail_q  <= '0;
      walk_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        HB_IDLE: begin
          if (alloc_en_o) tail_q <= ptr_inc(tail_q);
          if (retire_o)   head_q <= ptr_inc(head_q);
          cnt_q <= cnt_q + CNT_W'(alloc_en_o) - CNT_W'(retire_o);
          if (start_rb) begin
            state_q <= HB_ROLL;
            walk_q  <= ptr_dec(tail_q);
          end
        end
        HB_ROLL: begin
          if (walk_q == head_q) state_q <= HB_DONE;
          else                  walk_q  <= ptr_dec(walk_q);
        end
        HB_DONE: begin
          state_q <= HB_IDLE;
          head_q  <= '0;
          tail_q  <= '0;
          cnt_q   <= '0;
        end
        default: state_q <= HB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/history_buffer.sv
module history_buffer #(
  parameter int DEPTH  = 8,
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [REG_W-1:0]  alloc_dest_i,
  output logic              alloc_ready_o,
  output logic [PTR_W-1:0]  alloc_tag_o,
  input  logic              cmpl_valid_i,
  input  logic [PTR_W-1:0]  cmpl_tag_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              retire_o,
  output logic              rollback_busy_o,
  output logic              rollback_done_o
);
  logic [DEPTH-1:0]             ent_valid, ent_done, ent_exc;
  logic [DEPTH-1:0][REG_W-1:0]  ent_dest;
  logic [DEPTH-1:0][DATA_W-1:0] ent_old;
  logic [PTR_W-1:0]             tail, head, walk;
  logic                         alloc_en, idle, rolling, clear;
  logic                         cmpl_acc, restore_en;
  logic [REG_W-1:0]             cmpl_dest, wr_addr;
  logic [DATA_W-1:0]            old_val, wr_data;

  hb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_valid_i (alloc_valid_i),
    .head_valid_i  (ent_valid[head]),
    .head_done_i   (ent_done[head]),
    .head_exc_i    (ent_exc[head]),
    .alloc_en_o    (alloc_en),
    .alloc_ready_o (alloc_ready_o),
    .tail_o        (tail),
    .head_o        (head),
    .walk_o        (walk),
    .retire_o      (retire_o),
    .idle_o        (idle),
    .rolling_o     (rolling),
    .clear_o       (clear)
  );

  assign cmpl_dest  = ent_dest[cmpl_tag_i];
  assign cmpl_acc   = cmpl_valid_i && idle && ent_valid[cmpl_tag_i] && !ent_done[cmpl_tag_i];
  assign restore_en = rolling && ent_valid[walk] && ent_done[walk];
  assign wr_addr    = restore_en ? ent_dest[walk] : cmpl_dest;
  assign wr_data    = restore_en ? ent_old[walk]  : cmpl_data_i;

  hb_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) ents_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (alloc_en),
    .alloc_idx_i  (tail),
    .alloc_dest_i (alloc_dest_i),
    .cmpl_en_i    (cmpl_acc),
    .cmpl_idx_i   (cmpl_tag_i),
    .cmpl_exc_i   (cmpl_exc_i),
    .cmpl_old_i   (old_val),
    .retire_en_i  (retire_o),
    .retire_idx_i (head),
    .clear_i      (clear),
    .valid_o      (ent_valid),
    .done_o       (ent_done),
    .exc_o        (ent_exc),
    .dest_o       (ent_dest),
    .old_o        (ent_old)
  );

  hb_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) rf_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .old_addr_i (cmpl_dest),
    .old_data_o (old_val),
    .wr_en_i    (restore_en || cmpl_acc),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data)
  );

  assign alloc_tag_o     = tail;
  assign rollback_busy_o = rolling;
  assign rollback_done_o = clear;
endmodule

// File: rtl/hb_chk.sv
module hb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic alloc_ready_o,
  input logic retire_o,
  input logic rollback_busy_o,
  input logic rollback_done_o,
  input logic cmpl_valid_i,
  input logic cmpl_acc
);
  // R6
  busy_blocks_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_busy_o |-> !alloc_ready_o);

  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_done_o |-> $past(rollback_busy_o));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_done_o |=> !rollback_done_o);

  // R5
  no_retire_in_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> !rollback_busy_o && !rollback_done_o);

  // R10
  cmpl_ignored_in_rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && (rollback_busy_o || rollback_done_o)) |-> !cmpl_acc);
endmodule

bind history_buffer hb_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .alloc_ready_o   (alloc_ready_o),
  .retire_o        (retire_o),
  .rollback_busy_o (rollback_busy_o),
  .rollback_done_o (rollback_done_o),
  .cmpl_valid_i    (cmpl_valid_i),
  .cmpl_acc        (cmpl_acc)
);

// File: tb/history_buffer_tb_top.sv
module history_buffer_tb_top;
  localparam int DEPTH  = 4;
  localparam int NREGS  = 4;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 2;
  localparam int REG_W  = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              alloc_valid_i = 1'b0;
  logic [REG_W-1:0]  alloc_dest_i = '0;
  logic              alloc_ready_o;
  logic [PTR_W-1:0]  alloc_tag_o;
  logic              cmpl_valid_i = 1'b0;
  logic [PTR_W-1:0]  cmpl_tag_i = '0;
  logic [DATA_W-1:0] cmpl_data_i = '0;
  logic              cmpl_exc_i = 1'b0;
  logic [REG_W-1:0]  rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              retire_o, rollback_busy_o, rollback_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int ret_cnt = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  history_buffer #(.DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(DATA_W)) dut_i (.*);

  always @(negedge clk_i) if (retire_o) ret_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    alloc_valid_i = 1'b0;
    cmpl_valid_i = 1'b0;
    cyc();
    rst_ni = 1'b1;
    cyc();
    ret_cnt = 0;
  endtask

  task automatic chk_reg(input int r, input int exp, input string req);
    rd_addr_i = REG_W'(r);
    #1;
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic alloc(input int dest, input int exp_tag);
    chk("R2 ready", int'(alloc_ready_o), 1);
    chk("R2 tag", int'(alloc_tag_o), exp_tag);
    alloc_valid_i = 1'b1;
    alloc_dest_i = REG_W'(dest);
    cyc();
    alloc_valid_i = 1'b0;
  endtask

  task automatic cmpl(input int tag, input int data, input bit exc);
    cmpl_valid_i = 1'b1;
    cmpl_tag_i = PTR_W'(tag);
    cmpl_data_i = DATA_W'(data);
    cmpl_exc_i = exc;
    cyc();
    cmpl_valid_i = 1'b0;
    cmpl_exc_i = 1'b0;
  endtask

  task automatic scenario(input int k, input int mask);
    int p[4], v[4], d[4], expr[4];
    int late, bc;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      p[i] = ((k * 16 + mask + i * 40 + 3) & 8'hFF) | 1;
      v[i] = (k * 37 + mask * 11 + i * 59 + 128) & 8'hFF;
      d[i] = (i + mask) % 4;
    end
    for (int i = 0; i < 4; i++) alloc(i, i);
    chk("R2 full", int'(alloc_ready_o), 0);
    for (int i = 0; i < 4; i++) cmpl(i, p[i], 1'b0);
    cyc();
    cyc();
    chk("R5 retire count", ret_cnt, 4);
    ret_cnt = 0;
    for (int r = 0; r < 4; r++) begin
      chk_reg(r, p[r], "R3");
      expr[r] = p[r];
    end
    for (int i = 0; i < k; i++) expr[d[i]] = v[i];
    for (int i = 0; i < 4; i++) alloc(d[i], i);
    for (int j = k + 1; j < 4; j++) begin
      if (mask[j]) begin
        cmpl(j, v[j], j[0]);
        chk_reg(d[j], v[j], "R3 early write");
      end
    end
    for (int i = 0; i < k; i++) cmpl(i, v[i], 1'b0);
    cmpl(k, v[k], 1'b1);
    chk("R6 not yet busy", int'(rollback_busy_o), 0);
    late = -1;
    for (int j = 3; j > k; j--) if (!mask[j]) late = j;
    if (late >= 0) begin
      cmpl(late, v[late] ^ 8'hFF, 1'b0);
      chk_reg(d[late], v[late] ^ 8'hFF, "R11 accepted");
    end else begin
      cyc();
    end
    bc = 0;
    while (rollback_busy_o && bc < 20) begin
      chk("R6 alloc blocked", int'(alloc_ready_o), 0);
      cmpl_valid_i = 1'b1;
      cmpl_tag_i = 2'd3;
      cmpl_data_i = 8'hEE;
      cyc();
      cmpl_valid_i = 1'b0;
      bc++;
    end
    chk("R7 busy cycles", bc, 4 - k);
    chk("R9 done pulse", int'(rollback_done_o), 1);
    chk("R5 retire before exc", ret_cnt, k);
    cmpl_valid_i = 1'b1;
    cmpl_tag_i = 2'd3;
    cmpl_data_i = 8'hEE;
    cyc();
    cmpl_valid_i = 1'b0;
    chk("R9 done one cycle", int'(rollback_done_o), 0);
    chk("R9 ready", int'(alloc_ready_o), 1);
    chk("R9 tag restart", int'(alloc_tag_o), 0);
    for (int r = 0; r < 4; r++) chk_reg(r, expr[r], "R7 R8 R10 R11 restored");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 ready", int'(alloc_ready_o), 1);
    chk("R1 tag", int'(alloc_tag_o), 0);
    chk("R1 retire", int'(retire_o), 0);
    chk("R1 busy", int'(rollback_busy_o), 0);
    chk("R1 done", int'(rollback_done_o), 0);
    for (int r = 0; r < 4; r++) chk_reg(r, 0, "R1 reg");

    // R4: unallocated tag, then double completion; R5: stalled head
    cmpl(2, 8'h77, 1'b0);
    for (int r = 0; r < 4; r++) chk_reg(r, 0, "R4 unallocated");
    alloc(1, 0);
    alloc(3, 1);
    cmpl(1, 8'h5A, 1'b0);
    cmpl(1, 8'hA5, 1'b0);
    chk_reg(3, 8'h5A, "R4 second completion");
    cyc();
    chk("R5 head blocks", ret_cnt, 0);
    cmpl(0, 8'h21, 1'b0);
    cyc();
    cyc();
    chk("R5 in-order retire", ret_cnt, 2);
    chk_reg(1, 8'h21, "R3");

    // R7: same register written three times, restored youngest first
    do_reset();
    alloc(0, 0);
    alloc(2, 1);
    alloc(2, 2);
    alloc(2, 3);
    cmpl(1, 8'h11, 1'b0);
    cmpl(2, 8'h22, 1'b0);
    cmpl(3, 8'h33, 1'b0);
    chk_reg(2, 8'h33, "R3 last write");
    cmpl(0, 8'h44, 1'b1);
    cyc();
    while (rollback_busy_o) cyc();
    cyc();
    chk_reg(2, 0, "R7 youngest first");
    chk_reg(0, 0, "R7 head restored");

    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 16; m++) scenario(k, m);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule